// File: doc/BRIEF.md
# Tone Cadence Timer Controller

This block switches a tone oscillator on and off in a repeating cadence. Two 16-bit down counters share one 8 kHz strobe, so one count is 125 µs. One counter measures the on interval and the other the off interval. While the oscillator is enabled, the controller alternates between the two intervals. Each interval loads its length from its own period input at the moment the interval starts.

Each counter has its own enable. If the on-interval counter is disabled, the tone stays on. If the off-interval counter is disabled, the tone stays off once it has gone off. An optional mode holds the tone on past the end of the on interval until the next zero crossing of the waveform, so the tone never stops mid-cycle. The sinusoid itself is generated elsewhere and is seen here only as a zero-crossing strobe.

The block has four outputs:
- a gate that enables the oscillator;
- a status bit that shows whether the signal is active;
- a one-cycle pulse when the on-interval counter expires;
- a one-cycle pulse when the off-interval counter expires.

Top module: `tone_cadence_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `osc_gate`, `sig_active`, `act_exp_irq` and `inact_exp_irq` are all 0.
- R2: With `osc_en` high and both counter enables low, `osc_gate` rises in the cycle after `osc_en` is sampled high and then stays high.
- R3: With `act_tmr_en` high and `zc_wait_en` low, an on interval that starts at strobe count t ends on strobe t+`act_period`. On that strobe edge `osc_gate` falls and `act_exp_irq` pulses. A period of 0 behaves like 1.
- R4: An off interval that starts on strobe t, with `inact_tmr_en` high, ends on strobe t+`inact_period`. On that strobe edge `inact_exp_irq` pulses and `osc_gate` rises again.
- R5: While `osc_en` and both counter enables stay high, on and off intervals keep alternating without limit.
- R6: With `act_tmr_en` high and `inact_tmr_en` low, `osc_gate` falls when the on interval expires and stays low.
- R7: With `zc_wait_en` high, expiry of the on interval still pulses `act_exp_irq`, but `osc_gate` stays high. `osc_gate` falls at the first edge where `zero_cross` is sampled high, and the off interval starts there. A `zero_cross` pulse that arrives before expiry has no effect.
- R8: `osc_en` sampled low forces `osc_gate` low at the next edge and reloads both counters. A later re-enable starts a full on interval.
- R9: Clearing both counter enables during an off interval keeps `osc_gate` low and stops any further interrupt pulses.
- R10: `sig_active` always equals `osc_gate`.
- R11: `act_exp_irq` and `inact_exp_irq` are each one cycle wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_8k | input | 1 | One-cycle strobe, 8 kHz, 125 µs per count |
| osc_en | input | 1 | Oscillator enable |
| act_tmr_en | input | 1 | On-interval counter enable |
| inact_tmr_en | input | 1 | Off-interval counter enable |
| act_period | input | 16 | On-interval length in strobes |
| inact_period | input | 16 | Off-interval length in strobes |
| zc_wait_en | input | 1 | Hold turn-off until the next zero crossing |
| zero_cross | input | 1 | Zero-crossing strobe from the oscillator |
| osc_gate | output | 1 | Oscillator gate |
| sig_active | output | 1 | Status: signal active |
| act_exp_irq | output | 1 | On-interval expiry pulse |
| inact_exp_irq | output | 1 | Off-interval expiry pulse |

## Verification
The assertions assume that every input is synchronous to `clk` and that `tick_8k` and `zero_cross` are strobes. The bench keeps within these assumptions in two ways:
- It changes inputs only on the falling clock edge.
- It spaces strobes five cycles apart and drives enables, periods and `zero_cross` only on the cycle right after a strobe.

As a result, no input change ever shares an edge with a strobe. Every expected gate or interrupt event can then be tagged with an exact strobe count.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int TMR_W   = 16;
  localparam int NUM_TMR = 2;
  localparam int IDX_ACT = 0;
  localparam int IDX_INA = 1;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ACT   = 2'd1,
    ST_WZC   = 2'd2,
    ST_INACT = 2'd3
  } cad_state_e;
endpackage

// File: rtl/cadence_down_cnt.sv
module cadence_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  // Expiry on the strobe that sees one count left; a value of 0 acts like 1.
  assign expire_o = run_i && (cnt_q <= W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && !expire_o) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  // R8: a counter that is neither loaded nor running keeps its count
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cadence_fsm.sv
module cadence_fsm import tcc_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               osc_en_i,
  input  logic               act_en_i,
  input  logic               inact_en_i,
  input  logic               zc_en_i,
  input  logic               zero_cross_i,
  input  logic [NUM_TMR-1:0] expire_i,
  output logic [NUM_TMR-1:0] load_o,
  output logic [NUM_TMR-1:0] run_o,
  output logic               gate_o,
  output logic               status_o,
  output logic               act_irq_o,
  output logic               inact_irq_o
);
  cad_state_e state_q, state_d;
  logic       on_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (osc_en_i) state_d = ST_ACT;
      ST_ACT: begin
        if (!osc_en_i)                  state_d = ST_OFF;
        else if (expire_i[IDX_ACT])     state_d = zc_en_i ? ST_WZC : ST_INACT;
      end
      ST_WZC: begin
        if (!osc_en_i)                  state_d = ST_OFF;
        else if (zero_cross_i || !zc_en_i) state_d = ST_INACT;
      end
      ST_INACT: begin
        if (!osc_en_i)                  state_d = ST_OFF;
        else if (expire_i[IDX_INA])     state_d = ST_ACT;
      end
      default:                          state_d = ST_OFF;
    endcase
  end

  // Each counter reloads in every cycle its interval is not running.
  always_comb begin
    load_o[IDX_ACT] = (state_q != ST_ACT);
    load_o[IDX_INA] = (state_q != ST_INACT);
    run_o[IDX_ACT]  = tick_i && osc_en_i && act_en_i   && (state_q == ST_ACT);
    run_o[IDX_INA]  = tick_i && osc_en_i && inact_en_i && (state_q == ST_INACT);
  end

  assign on_d = (state_d == ST_ACT) || (state_d == ST_WZC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OFF;
      gate_o      <= 1'b0;
      status_o    <= 1'b0;
      act_irq_o   <= 1'b0;
      inact_irq_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      gate_o      <= on_d;
      status_o    <= on_d;
      act_irq_o   <= expire_i[IDX_ACT];
      inact_irq_o <= expire_i[IDX_INA];
    end
  end

  // R8: disabling the oscillator turns the gate off at the next edge
  a_r8_off_forces: assert property (@(posedge clk) disable iff (rst)
    !osc_en_i |=> !gate_o);
  // R2: the gate only rises while the oscillator is enabled
  a_r2_rise_needs_en: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> $past(osc_en_i));
  // R3: without zero-crossing wait, on-interval expiry coincides with gate off
  a_r3_act_off: assert property (@(posedge clk) disable iff (rst)
    (act_irq_o && !$past(zc_en_i)) |-> !gate_o);
  // R4: off-interval expiry coincides with gate on
  a_r4_inact_on: assert property (@(posedge clk) disable iff (rst)
    inact_irq_o |-> gate_o);
  // R7: while waiting for a crossing, the gate holds high
  a_r7_zc_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_WZC && $past(osc_en_i) && $past(zc_en_i) &&
     !$past(zero_cross_i)) |-> gate_o);
  // R11: interrupt pulses are single-cycle and exclusive
  a_r11_act_pulse: assert property (@(posedge clk) disable iff (rst)
    act_irq_o |=> !act_irq_o);
  a_r11_inact_pulse: assert property (@(posedge clk) disable iff (rst)
    inact_irq_o |=> !inact_irq_o);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(act_irq_o && inact_irq_o));
endmodule

// File: rtl/tone_cadence_ctrl.sv
module tone_cadence_ctrl import tcc_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_8k,
  input  logic             osc_en,
  input  logic             act_tmr_en,
  input  logic             inact_tmr_en,
  input  logic [TMR_W-1:0] act_period,
  input  logic [TMR_W-1:0] inact_period,
  input  logic             zc_wait_en,
  input  logic             zero_cross,
  output logic             osc_gate,
  output logic             sig_active,
  output logic             act_exp_irq,
  output logic             inact_exp_irq
);
  logic [NUM_TMR-1:0] load, run, expire;
  logic [TMR_W-1:0]   period [NUM_TMR];

  assign period[IDX_ACT] = act_period;
  assign period[IDX_INA] = inact_period;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    cadence_down_cnt #(.W(TMR_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .load_i     (load[g]),
      .load_val_i (period[g]),
      .run_i      (run[g]),
      .expire_o   (expire[g])
    );
  end

  cadence_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_8k),
    .osc_en_i     (osc_en),
    .act_en_i     (act_tmr_en),
    .inact_en_i   (inact_tmr_en),
    .zc_en_i      (zc_wait_en),
    .zero_cross_i (zero_cross),
    .expire_i     (expire),
    .load_o       (load),
    .run_o        (run),
    .gate_o       (osc_gate),
    .status_o     (sig_active),
    .act_irq_o    (act_exp_irq),
    .inact_irq_o  (inact_exp_irq)
  );

  // R10: status output follows the gate
  a_r10_status_eq: assert property (@(posedge clk) disable iff (rst)
    sig_active == osc_gate);
endmodule

// File: tb/tone_cadence_ctrl_tb_top.sv
module tone_cadence_ctrl_tb_top;
  localparam int K_ON = 0, K_OFF = 1, K_AIRQ = 2, K_IIRQ = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, tick = 1'b0, osc_en = 1'b0;
  logic        act_en = 1'b0, inact_en = 1'b0, zc_en = 1'b0, zc = 1'b0;
  logic [15:0] act_p = 16'd1, inact_p = 16'd1;
  logic        gate, status, airq, iirq;

  tone_cadence_ctrl dut_i (
    .clk(clk), .rst(rst), .tick_8k(tick), .osc_en(osc_en),
    .act_tmr_en(act_en), .inact_tmr_en(inact_en),
    .act_period(act_p), .inact_period(inact_p),
    .zc_wait_en(zc_en), .zero_cross(zc),
    .osc_gate(gate), .sig_active(status),
    .act_exp_irq(airq), .inact_exp_irq(iirq)
  );

  // Strobe generator: one high cycle in five; counts strobes seen at the edge.
  int phase = 0;
  int tick_cnt = 0;
  always @(negedge clk) begin
    phase <= (phase == 4) ? 0 : phase + 1;
    tick  <= (phase == 4);
  end
  always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

  typedef struct { int kind; int at; } ev_t;
  ev_t   exp_q[$];
  string req_q[$];
  int vectors = 0, miscompares = 0;

  task automatic expect_ev(int k, int t, string r);
    ev_t e;
    e.kind = k; e.at = t;
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  task automatic check_ev(int k);
    ev_t   e;
    string r;
    vectors++;
    if (exp_q.size() == 0) begin
      miscompares++;
      $display("FAIL R9 unexpected event: actual kind %0d at tick %0d, expected none", k, tick_cnt);
    end else begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      if (e.kind != k || e.at != tick_cnt) begin
        miscompares++;
        $display("FAIL %s: actual kind %0d at tick %0d, expected kind %0d at tick %0d",
                 r, k, tick_cnt, e.kind, e.at);
      end
    end
  endtask

  task automatic drained(string r);
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL %s: actual %0d events missing, expected 0", r, exp_q.size());
      exp_q.delete();
      req_q.delete();
    end
  endtask

  // Monitor: pops and compares as events appear at the outputs.
  logic gate_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (airq) check_ev(K_AIRQ);
      if (iirq) check_ev(K_IIRQ);
      if (gate != gate_prev) begin
        check_ev(gate ? K_ON : K_OFF);
        vectors++;
        if (status != gate) begin
          miscompares++;
          $display("FAIL R10: actual status %0b, expected %0b", status, gate);
        end
      end
    end
    gate_prev = gate;
  end

  task automatic go_to(int k);
    do @(negedge clk); while (tick_cnt < k);
  endtask

  task automatic zc_pulse();
    zc = 1'b1;
    @(negedge clk);
    zc = 1'b0;
  endtask

  int t0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual run still busy, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (gate || status || airq || iirq) begin
      miscompares++;
      $display("FAIL R1: actual %0b%0b%0b%0b, expected 0000", gate, status, airq, iirq);
    end

    // R2: continuous tone with no counters enabled
    t0 = tick_cnt + 1;
    expect_ev(K_ON, t0, "R2");
    expect_ev(K_OFF, t0 + 15, "R8");
    go_to(t0); osc_en = 1'b1;
    go_to(t0 + 15); osc_en = 1'b0;
    go_to(t0 + 17); drained("R2");

    // R3 R4 R5: repeating cadence
    act_p = 16'd3; inact_p = 16'd2; act_en = 1'b1; inact_en = 1'b1;
    t0 = tick_cnt + 1;
    expect_ev(K_ON,   t0,      "R3");
    expect_ev(K_AIRQ, t0 + 3,  "R3");
    expect_ev(K_OFF,  t0 + 3,  "R3");
    expect_ev(K_IIRQ, t0 + 5,  "R4");
    expect_ev(K_ON,   t0 + 5,  "R4");
    expect_ev(K_AIRQ, t0 + 8,  "R5");
    expect_ev(K_OFF,  t0 + 8,  "R5");
    expect_ev(K_IIRQ, t0 + 10, "R5");
    expect_ev(K_ON,   t0 + 10, "R5");
    expect_ev(K_OFF,  t0 + 11, "R8");
    go_to(t0); osc_en = 1'b1;
    go_to(t0 + 11); osc_en = 1'b0;
    go_to(t0 + 12); drained("R5");

    // R6: only the on-interval counter enabled
    act_p = 16'd4; inact_en = 1'b0;
    t0 = tick_cnt + 1;
    expect_ev(K_ON,   t0,     "R6");
    expect_ev(K_AIRQ, t0 + 4, "R6");
    expect_ev(K_OFF,  t0 + 4, "R6");
    go_to(t0); osc_en = 1'b1;
    go_to(t0 + 20); osc_en = 1'b0;
    go_to(t0 + 21); drained("R6");

    // R7: turn-off waits for a zero crossing; an early crossing is ignored
    act_p = 16'd2; inact_p = 16'd3; inact_en = 1'b1; zc_en = 1'b1;
    t0 = tick_cnt + 1;
    expect_ev(K_ON,   t0,     "R7");
    expect_ev(K_AIRQ, t0 + 2, "R7");
    expect_ev(K_OFF,  t0 + 3, "R7");
    expect_ev(K_IIRQ, t0 + 6, "R7");
    expect_ev(K_ON,   t0 + 6, "R7");
    expect_ev(K_OFF,  t0 + 7, "R8");
    go_to(t0); osc_en = 1'b1;
    go_to(t0 + 1); zc_pulse();
    go_to(t0 + 3); zc_pulse();
    go_to(t0 + 7); osc_en = 1'b0; zc_en = 1'b0;
    go_to(t0 + 8); drained("R7");

    // R8: disable mid-interval, then a full interval after re-enable
    act_p = 16'd3; inact_p = 16'd2;
    t0 = tick_cnt + 1;
    expect_ev(K_ON,   t0,     "R8");
    expect_ev(K_OFF,  t0 + 2, "R8");
    expect_ev(K_ON,   t0 + 3, "R8");
    expect_ev(K_AIRQ, t0 + 6, "R8");
    expect_ev(K_OFF,  t0 + 6, "R8");
    go_to(t0); osc_en = 1'b1;
    go_to(t0 + 2); osc_en = 1'b0;
    go_to(t0 + 3); osc_en = 1'b1;
    go_to(t0 + 7); osc_en = 1'b0;
    go_to(t0 + 8); drained("R8");

    // R9: clearing both enables during the off interval halts the cadence
    act_p = 16'd2; inact_p = 16'd4;
    t0 = tick_cnt + 1;
    expect_ev(K_ON,   t0,     "R9");
    expect_ev(K_AIRQ, t0 + 2, "R9");
    expect_ev(K_OFF,  t0 + 2, "R9");
    go_to(t0); osc_en = 1'b1;
    go_to(t0 + 3); act_en = 1'b0; inact_en = 1'b0;
    go_to(t0 + 20); osc_en = 1'b0;
    go_to(t0 + 21); drained("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule